// File: doc/BRIEF.md
# Single-Page Write-Back Flash Cache

This block is a byte-addressed front end for a page-organised flash device. It holds exactly one page in a local buffer, together with a tag naming that page and a flag recording whether the buffer differs from the device. A host issues commands that name an operation, a start address and a byte count. Data moves one byte per handshake, write bytes in and read bytes out. Whole-page transfers to and from the device are delegated to a page sequencer, which the block drives through a request/done pair. The sequencer takes write-back bytes or supplies fill bytes one at a time.

The linear address space covers every page except the last one. The last page is kept for configuration data and is reached only through two dedicated commands. A configuration write always commits its page to the device before it completes. Every command ends with a one-cycle completion pulse and a success flag.

Top module: `flash_page_cache`

## Requirements
- R1: A linear address is split into a page number (address shifted right by the page shift) and an offset (address AND page size minus one). An access that runs past the end of a page continues at offset 0 of the next page, and its read bytes come back in address order.
- R2: After reset the tag holds the all-ones "no page" value, so the first access always fills. `cmd_ready` is high, and `pg_req`, `rd_valid` and `done` are low.
- R3: When an access reaches a page other than the cached one and the cache is dirty, the cached page is written back first. The dirty flag then clears, the tag takes the new page, and the new page is read in. A clean miss only reads in the new page.
- R4: A write segment that starts at offset 0 and has at least one page of bytes left does not read the page in. It only writes back the old page if that page is dirty, then retags the cache.
- R5: Accepting a write byte sets the dirty flag. Reads never set it, so a later miss after reads alone causes no write-back.
- R6: The data region is the device size minus one page. A linear read or write whose start address is at or beyond that size, or whose start plus length exceeds it, completes with `ok`=0. It transfers no bytes and issues no sequencer request.
- R7: The configuration page is the last page of the device. A configuration write reads that page in if it is not cached, overwrites bytes from offset 0, and writes the page back before `done`. A configuration read is served from that page. A configuration command longer than one page completes with `ok`=0.
- R8: A flush command writes the cached page back only if it is dirty. Otherwise it completes with no sequencer request.
- R9: Command codes on `cmd_op` are 0 read, 1 write, 2 flush, 3 configuration read and 4 configuration write. `cmd_ready` is high only when idle. `wr_ready` and `cmd_ready` stay low while a sequencer request is open. One write byte is taken per `wr_valid`/`wr_ready` cycle, and `done` is a single-cycle pulse.
- R10: `pg_req` stays high with a stable `pg_wr` and `pg_page` until `pg_done`. During a write-back (`pg_wr`=1), `pg_wb_data` shows buffer byte 0 first and advances once per `pg_wb_take`. During a fill, each `pg_fill_valid` cycle stores `pg_fill_data` into the next buffer byte, starting at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle |
| cmd_op | input | 3 | Operation code (R9) |
| cmd_addr | input | ADDR_W | Linear start address |
| cmd_len | input | ADDR_W+1 | Byte count |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte accepted this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Command complete pulse |
| ok | output | 1 | Command succeeded, valid with done |
| pg_req | output | 1 | Sequencer page operation open |
| pg_wr | output | 1 | 1 write-back, 0 fill |
| pg_page | output | TAG_W | Page number of the operation |
| pg_fill_valid | input | 1 | Fill byte present |
| pg_fill_data | input | 8 | Fill byte |
| pg_wb_take | input | 1 | Sequencer consumes the shown write-back byte |
| pg_wb_data | output | 8 | Write-back byte |
| pg_done | input | 1 | Sequencer operation finished |

## Verification
The main function is tried with a cold first read, hits after a partial write, and a read that crosses a page boundary. It is also tried with a whole-page write from a clean cache and a 20-byte write that starts whole-page and then spills into a partial page. The exact sequence of write-back and fill requests observed on the sequencer tells a clean miss apart from a dirty one, and tells a skipped fill apart from a performed one. Out-of-range starts, ends one byte past the region, oversize configuration commands, and repeated flushes of clean and dirty pages separate rejection and the dirty-only write-back from normal completion. A final comparison of the modelled device against the bench's logical memory shows that every written byte reached the flash.

// File: rtl/fpc_pkg.sv
// Shared encodings for the single-page flash cache.
package fpc_pkg;

    // Host command codes (values are part of the port contract)
    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_FLUSH  = 3'd2,
        OP_CFG_RD = 3'd3,
        OP_CFG_WR = 3'd4
    } op_e;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG,
        ST_WB,
        ST_FILL,
        ST_XFER,
        ST_DONE
    } state_e;

    // Why a write-back was started, which picks where it returns to
    typedef enum logic [1:0] {
        WB_MISS,
        WB_FLUSH,
        WB_COMMIT
    } wb_cause_e;

endpackage

// File: rtl/fpc_range_chk.sv
// Range check for a linear access.
// Flags an access whose start is at or past LIMIT, or whose end
// (start + length) is past LIMIT. Assumes LIMIT fits in LEN_W+1 bits.
module fpc_range_chk #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 9,
    parameter int LIMIT  = 240,
    localparam int SUM_W = LEN_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              bad
);

    logic [SUM_W-1:0] start_w;
    logic [SUM_W-1:0] end_w;

    // widen both operands so the sum cannot wrap
    always_comb begin
        start_w = SUM_W'(addr);
        end_w   = start_w + SUM_W'(len);
        bad     = (start_w >= SUM_W'(LIMIT)) || (end_w > SUM_W'(LIMIT));
    end

endmodule

// File: rtl/fpc_page_buf.sv
// One-page byte buffer with one write port and one asynchronous read port.
// Contents are undefined after reset. The controller never reads a byte
// before it has been filled or written.
module fpc_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] mem [PAGE_BYTES];

    // store one byte per cycle
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // combinational read for write-back and host reads
    assign rdata = mem[raddr];

endmodule

// File: rtl/fpc_idx_cnt.sv
// Byte index used while streaming a page to or from the sequencer.
// It clears when asked, otherwise it steps once per transferred byte
// and wraps at the page size.
module fpc_idx_cnt #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx
);

    // step or clear the streaming index
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/flash_page_cache.sv
// Single-page write-back cache in front of a page-level flash sequencer.
// Commands name an operation, a start address and a length. Bytes then move
// one per cycle: write bytes through wr_valid/wr_ready, read bytes out on
// rd_valid. Misses are resolved with whole-page write-back and fill requests
// to the sequencer. The last device page is reserved for configuration data.
// Assumes PAGE_COUNT is a power of two of at least 2, and TAG_W exceeds the
// page-number width.
module flash_page_cache
    import fpc_pkg::*;
#(
    parameter int PAGE_SHIFT  = 4,
    parameter int PAGE_COUNT  = 16,
    parameter int TAG_W       = 16,
    localparam int PAGE_BYTES = 1 << PAGE_SHIFT,
    localparam int DEV_BYTES  = PAGE_BYTES * PAGE_COUNT,
    localparam int ADDR_W     = $clog2(DEV_BYTES),
    localparam int LEN_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              ok,
    output logic              pg_req,
    output logic              pg_wr,
    output logic [TAG_W-1:0]  pg_page,
    input  logic              pg_fill_valid,
    input  logic [7:0]        pg_fill_data,
    input  logic              pg_wb_take,
    output logic [7:0]        pg_wb_data,
    input  logic              pg_done
);

    localparam int PNUM_W     = ADDR_W - PAGE_SHIFT;
    localparam int DATA_BYTES = DEV_BYTES - PAGE_BYTES;
    localparam int CFG_PAGE   = PAGE_COUNT - 1;
    localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(CFG_PAGE * PAGE_BYTES);
    localparam logic [LEN_W-1:0]  PAGE_LEN = LEN_W'(PAGE_BYTES);
    localparam logic [TAG_W-1:0]  NO_PAGE  = '1;

    state_e                  state;
    op_e                     op_q;
    wb_cause_e               cause_q;
    logic [ADDR_W-1:0]       pos_q;
    logic [LEN_W-1:0]        rem_q;
    logic [TAG_W-1:0]        tag_q;
    logic [TAG_W-1:0]        tgt_q;
    logic                    dirty_q;
    logic                    fill_q;
    logic                    ok_q;
    logic                    rd_valid_q;
    logic [7:0]              rd_data_q;

    logic [PAGE_SHIFT-1:0]   off;
    logic [TAG_W-1:0]        seg_page;
    logic                    is_hit;
    logic                    whole_wr;
    logic                    is_rd_op;
    logic                    rng_bad;
    logic                    in_wb;
    logic                    in_fill;
    logic [PAGE_SHIFT-1:0]   idx;
    logic                    buf_we;
    logic [PAGE_SHIFT-1:0]   buf_waddr;
    logic [7:0]              buf_wdata;
    logic [PAGE_SHIFT-1:0]   buf_raddr;
    logic [7:0]              buf_rdata;

    // split the current position into page number and offset
    always_comb begin
        off      = pos_q[PAGE_SHIFT-1:0];
        seg_page = {{(TAG_W-PNUM_W){1'b0}}, pos_q[ADDR_W-1:PAGE_SHIFT]};
        is_hit   = (tag_q == seg_page);
        whole_wr = (op_q == OP_WRITE) && (off == '0) && (rem_q >= PAGE_LEN);
        is_rd_op = (op_q == OP_READ) || (op_q == OP_CFG_RD);
        in_wb    = (state == ST_WB);
        in_fill  = (state == ST_FILL);
    end

    // linear accesses must stay inside the data region
    fpc_range_chk #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .LIMIT  (DATA_BYTES)
    ) u_range (
        .addr (cmd_addr),
        .len  (cmd_len),
        .bad  (rng_bad)
    );

    // streaming index for sequencer transfers
    fpc_idx_cnt #(
        .IDX_W (PAGE_SHIFT)
    ) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pg_done || !(in_wb || in_fill)),
        .inc   ((in_fill && pg_fill_valid) || (in_wb && pg_wb_take)),
        .idx   (idx)
    );

    // buffer port steering: fill bytes or host write bytes in; write-back or host read out
    always_comb begin
        buf_we    = (in_fill && pg_fill_valid) || (wr_valid && wr_ready);
        buf_waddr = in_fill ? idx : off;
        buf_wdata = in_fill ? pg_fill_data : wr_data;
        buf_raddr = in_wb ? idx : off;
    end

    fpc_page_buf #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    // command sequencing, tag and dirty tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_q       <= OP_READ;
            cause_q    <= WB_MISS;
            pos_q      <= '0;
            rem_q      <= '0;
            tag_q      <= NO_PAGE;
            tgt_q      <= NO_PAGE;
            dirty_q    <= 1'b0;
            fill_q     <= 1'b0;
            ok_q       <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q  <= op_e'(cmd_op);
                        rem_q <= cmd_len;
                        ok_q  <= 1'b1;
                        case (op_e'(cmd_op))
                            OP_READ, OP_WRITE: begin
                                pos_q <= cmd_addr;
                                if (rng_bad) begin
                                    ok_q  <= 1'b0;
                                    state <= ST_DONE;
                                end else if (cmd_len == '0) begin
                                    state <= ST_DONE;
                                end else begin
                                    state <= ST_SEG;
                                end
                            end
                            OP_CFG_RD, OP_CFG_WR: begin
                                pos_q <= CFG_BASE;
                                if (cmd_len > PAGE_LEN) begin
                                    ok_q  <= 1'b0;
                                    state <= ST_DONE;
                                end else begin
                                    state <= ST_SEG;
                                end
                            end
                            OP_FLUSH: begin
                                cause_q <= WB_FLUSH;
                                state   <= dirty_q ? ST_WB : ST_DONE;
                            end
                            default: begin
                                ok_q  <= 1'b0;
                                state <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_SEG: begin
                    if (is_hit) begin
                        state <= ST_XFER;
                    end else begin
                        tgt_q   <= seg_page;
                        fill_q  <= !whole_wr;
                        cause_q <= WB_MISS;
                        if (dirty_q) begin
                            state <= ST_WB;
                        end else begin
                            tag_q <= seg_page;
                            state <= whole_wr ? ST_XFER : ST_FILL;
                        end
                    end
                end
                ST_WB: begin
                    if (pg_done) begin
                        dirty_q <= 1'b0;
                        if (cause_q == WB_MISS) begin
                            tag_q <= tgt_q;
                            state <= fill_q ? ST_FILL : ST_XFER;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_FILL: begin
                    if (pg_done) begin
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (rem_q == '0) begin
                        if (op_q == OP_CFG_WR) begin
                            dirty_q <= 1'b1;
                            cause_q <= WB_COMMIT;
                            state   <= ST_WB;
                        end else begin
                            state <= ST_DONE;
                        end
                    end else if (is_rd_op || wr_valid) begin
                        if (is_rd_op) begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= buf_rdata;
                        end else begin
                            dirty_q <= 1'b1;
                        end
                        pos_q <= pos_q + 1'b1;
                        rem_q <= rem_q - 1'b1;
                        if ((off == '1) && (rem_q > LEN_W'(1))) begin
                            state <= ST_SEG;
                        end
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // port outputs
    assign cmd_ready  = (state == ST_IDLE);
    assign wr_ready   = (state == ST_XFER) && !is_rd_op && (rem_q != '0);
    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_data_q;
    assign done       = (state == ST_DONE);
    assign ok         = ok_q;
    assign pg_req     = in_wb || in_fill;
    assign pg_wr      = in_wb;
    assign pg_page    = tag_q;
    assign pg_wb_data = buf_rdata;

endmodule

// File: rtl/fpc_chk.sv
// Protocol and rejection checks for flash_page_cache, attached by bind.
module fpc_chk #(
    parameter int PAGE_SHIFT  = 4,
    parameter int PAGE_COUNT  = 16,
    parameter int TAG_W       = 16,
    localparam int PAGE_BYTES = 1 << PAGE_SHIFT,
    localparam int DEV_BYTES  = PAGE_BYTES * PAGE_COUNT,
    localparam int ADDR_W     = $clog2(DEV_BYTES),
    localparam int LEN_W      = ADDR_W + 1,
    localparam int DATA_BYTES = DEV_BYTES - PAGE_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              wr_ready,
    input logic              done,
    input logic              ok,
    input logic              pg_req,
    input logic              pg_wr,
    input logic [TAG_W-1:0]  pg_page,
    input logic              pg_done
);

    // R2
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !pg_req && !done));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req && !pg_done) |=> (pg_req && $stable(pg_wr) && $stable(pg_page)));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> (!cmd_ready && !wr_ready));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    wb_named_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_req && pg_wr) |-> (pg_page != {TAG_W{1'b1}}));

    // R6
    range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == 3'd0 || cmd_op == 3'd1) &&
         (int'(cmd_addr) >= DATA_BYTES)) |=> (done && !ok));

    // R7
    cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == 3'd3 || cmd_op == 3'd4) &&
         (int'(cmd_len) > PAGE_BYTES)) |=> (done && !ok));

endmodule

bind flash_page_cache fpc_chk #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .PAGE_COUNT (PAGE_COUNT),
    .TAG_W      (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .wr_ready  (wr_ready),
    .done      (done),
    .ok        (ok),
    .pg_req    (pg_req),
    .pg_wr     (pg_wr),
    .pg_page   (pg_page),
    .pg_done   (pg_done)
);

// File: tb/sim_flash_page_cache.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks push expected read bytes and sequencer operations,
// monitor processes pop and compare them as the design produces them.
module sim_flash_page_cache;

    localparam int PS   = 4;
    localparam int PC   = 16;
    localparam int PB   = 1 << PS;
    localparam int DEV  = PB * PC;
    localparam int DATA = DEV - PB;
    localparam int AW   = $clog2(DEV);
    localparam int LW   = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    wr_data = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          done;
    logic          ok;
    logic          pg_req;
    logic          pg_wr;
    logic [15:0]   pg_page;
    logic          pg_fill_valid = 1'b0;
    logic [7:0]    pg_fill_data = '0;
    logic          pg_wb_take = 1'b0;
    logic [7:0]    pg_wb_data;
    logic          pg_done = 1'b0;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    logic [7:0]  flash [DEV];
    logic [7:0]  refm  [DEV];
    logic [7:0]  exp_rd [$];
    logic [16:0] exp_ops [$];

    always #2 clk = ~clk;

    flash_page_cache #(.PAGE_SHIFT(PS), .PAGE_COUNT(PC), .TAG_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .ok(ok),
        .pg_req(pg_req), .pg_wr(pg_wr), .pg_page(pg_page),
        .pg_fill_valid(pg_fill_valid), .pg_fill_data(pg_fill_data),
        .pg_wb_take(pg_wb_take), .pg_wb_data(pg_wb_data), .pg_done(pg_done)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic exp_op(input bit wr, input int page);
        exp_ops.push_back({wr, 16'(page)});
    endtask

    // sequencer model: checks each requested operation, then serves it
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pg_req) begin
                automatic bit w = pg_wr;
                automatic int pg = int'(pg_page) % PC;
                automatic logic [16:0] got = {pg_wr, pg_page};
                if (exp_ops.size() == 0) begin
                    chk(1'b0, {cur_req, " unexpected sequencer op"}, int'(got), -1);
                end else begin
                    automatic logic [16:0] e = exp_ops.pop_front();
                    chk(got == e, {cur_req, " sequencer op {wr,page}"}, int'(got), int'(e));
                end
                for (int i = 0; i < PB; i++) begin
                    if (w) begin
                        flash[pg*PB+i] = pg_wb_data;
                        pg_wb_take = 1'b1;
                    end else begin
                        pg_fill_data  = flash[pg*PB+i];
                        pg_fill_valid = 1'b1;
                    end
                    @(negedge clk);
                end
                pg_wb_take    = 1'b0;
                pg_fill_valid = 1'b0;
                pg_done       = 1'b1;
                @(negedge clk);
                pg_done = 1'b0;
            end
        end
    end

    // read monitor: every returned byte must match the next expected one
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R9 unexpected read byte", int'(rd_data), -1);
                end else begin
                    automatic logic [7:0] e = exp_rd.pop_front();
                    chk(rd_data == e, "R1 read data", int'(rd_data), int'(e));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // issue one command, feed write bytes, wait for completion
    task automatic run_cmd(input int op, input int addr, input int len,
                           input bit exp_ok, input string req, input int seed);
        int base;
        cur_req = req;
        base = (op >= 3) ? DATA : addr;
        if (exp_ok && (op == 0 || op == 3)) begin
            for (int i = 0; i < len; i++) exp_rd.push_back(refm[base+i]);
        end
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_addr  = AW'(addr);
        cmd_len   = LW'(len);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_ok && (op == 1 || op == 4)) begin
            for (int i = 0; i < len; i++) begin
                wr_valid = 1'b1;
                wr_data  = 8'((seed + 29 * i) & 255);
                refm[base+i] = wr_data;
                while (!wr_ready) @(negedge clk);
                @(negedge clk);
            end
            wr_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(ok == exp_ok, {req, " ok flag"}, int'(ok), int'(exp_ok));
        repeat (3) @(negedge clk);
        chk(exp_rd.size() == 0, {req, " read bytes outstanding"}, exp_rd.size(), 0);
        chk(exp_ops.size() == 0, {req, " sequencer ops outstanding"}, exp_ops.size(), 0);
        exp_rd.delete();
        exp_ops.delete();
    endtask

    initial begin
        for (int i = 0; i < DEV; i++) begin
            flash[i] = 8'((i * 7 + 3) & 255);
            refm[i]  = flash[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(cmd_ready == 1'b1, "R2 cmd_ready", int'(cmd_ready), 1);
        chk(pg_req == 1'b0, "R2 pg_req", int'(pg_req), 0);
        chk(rd_valid == 1'b0 && done == 1'b0, "R2 rd_valid/done", int'(rd_valid), 0);

        // R2 first access fills page 0
        exp_op(0, 0);
        run_cmd(0, 5, 3, 1, "R2", 0);
        // R5 write hit: no sequencer traffic
        run_cmd(1, 7, 2, 1, "R5", 17);
        // R1 read hit sees written bytes
        run_cmd(0, 6, 4, 1, "R1", 0);
        // R3 dirty miss: write-back page 0, then fill page 1
        exp_op(1, 0); exp_op(0, 1);
        run_cmd(0, 20, 2, 1, "R3", 0);
        // R5 reads left page 1 clean; R1 crossing into page 2
        exp_op(0, 2);
        run_cmd(0, 30, 4, 1, "R5", 0);
        // R4 whole-page write from a clean cache: no traffic at all
        run_cmd(1, 48, 16, 1, "R4", 101);
        // R4 whole page then partial page: W3, no fill, W4, fill 5
        exp_op(1, 3); exp_op(1, 4); exp_op(0, 5);
        run_cmd(1, 64, 20, 1, "R4", 55);
        // R3 read back whole-page data from the device
        exp_op(1, 5); exp_op(0, 3);
        run_cmd(0, 48, 2, 1, "R3", 0);
        // R8 clean flush, then dirty flush, then clean again
        run_cmd(2, 0, 0, 1, "R8", 0);
        run_cmd(1, 50, 1, 1, "R5", 200);
        exp_op(1, 3);
        run_cmd(2, 0, 0, 1, "R8", 0);
        run_cmd(2, 0, 0, 1, "R8", 0);
        // R6 rejections and boundary
        run_cmd(0, DATA, 1, 0, "R6", 0);
        run_cmd(1, DATA - 2, 3, 0, "R6", 9);
        exp_op(0, 14);
        run_cmd(0, DATA - 2, 2, 1, "R6", 0);
        // R7 configuration write: fill last page, commit immediately
        exp_op(0, PC - 1); exp_op(1, PC - 1);
        run_cmd(4, 0, 4, 1, "R7", 77);
        run_cmd(3, 0, PB, 1, "R7", 0);
        run_cmd(3, 0, PB + 1, 0, "R7", 0);
        run_cmd(4, 0, PB + 1, 0, "R7", 0);
        // R10 final page through full protocol, then device image check
        exp_op(0, 6);
        run_cmd(1, 100, 1, 1, "R10", 3);
        exp_op(1, 6);
        run_cmd(2, 0, 0, 1, "R8", 0);
        begin
            int mism = 0;
            for (int i = 0; i < DEV; i++) if (flash[i] !== refm[i]) mism++;
            chk(mism == 0, "R10 device image mismatches", mism, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule